// File: doc/BRIEF.md
# Clock Source Selector with Stopped-Clock Fallback

This block chooses which of two oscillators drives the system clock and keeps watch on the external one. After reset it runs from the internal oscillator. Software raises a select request to move to the external oscillator (4 to 24 MHz). The block turns the internal clock off and then turns the external clock on, so the two never drive the output together. While the external oscillator is selected, an activity monitor timed by the internal clock checks that it still runs.

If the external clock stops, the block returns to the internal oscillator without any software action. It forces the dead branch off, sets a sticky failure flag and, if enabled, raises an interrupt. The flag stays set until software writes a one-cycle clear pulse. While the flag is set, a request for the external clock is ignored.

The control state machine runs on the internal clock and has six states. ST_INT: internal clock driving. ST_DROP_INT: internal gate being closed. ST_RAISE_EXT: external gate being opened. ST_EXT: external clock driving. ST_DROP_EXT: external gate being closed, or forced shut after a failure. ST_RAISE_INT: internal gate being reopened. The transitions are:
- ST_INT to ST_DROP_INT, on a request with no failure pending.
- ST_DROP_INT to ST_RAISE_EXT, once the internal gate is closed.
- ST_RAISE_EXT to ST_EXT, once the external gate is acknowledged open.
- ST_RAISE_EXT or ST_EXT to ST_DROP_EXT, on a stall or when the request drops.
- ST_DROP_EXT to ST_RAISE_INT, once the external acknowledge is gone.
- ST_RAISE_INT to ST_INT, once the internal gate is open.

Top module: `clk_fallback_sel`

## Requirements
- R1: After reset, active_src reads 2'b01 (internal), fail_flag and fail_irq are 0, and sys_clk runs at the internal clock rate.
- R2: With sel_ext high and no failure pending, active_src reaches 2'b10 (external) within 30 internal cycles, and sys_clk then runs at the external clock rate.
- R3: The two clock gates are never open together. active_src never reads 2'b11, and it reads 2'b00 (no source driving) during the gap of each switch.
- R4: When sel_ext drops while the external clock drives, active_src returns to 2'b01 within 30 internal cycles and no failure is flagged.
- R5: If the external clock stops while it is selected, fail_flag rises within 16 internal cycles. Once about 8 internal cycles pass with no sign of activity, active_src returns to 2'b01 and sys_clk runs at the internal rate, with no software action.
- R6: fail_irq is high exactly when fail_flag is set and irq_en is high.
- R7: fail_flag stays set until a one-cycle pulse on fail_clr, and it is 0 on the cycle after that pulse.
- R8: While fail_flag is set, a high sel_ext does not move the selection away from the internal clock. After the flag is cleared, the pending request is served.
- R9: While the internal clock is selected, a stopped external clock sets no failure.
- R10: If the external clock never starts after it has been requested, the block flags a failure and stays on, or returns to, the internal clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| int_clk | input | 1 | Internal oscillator; also clocks the control logic |
| ext_clk | input | 1 | External oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_ext | input | 1 | Software request: 1 selects the external clock |
| irq_en | input | 1 | Failure interrupt enable |
| fail_clr | input | 1 | One-cycle write-1 pulse that clears the failure flag |
| sys_clk | output | 1 | Gated system clock |
| active_src | output | 2 | Driving source: 01 internal, 10 external, 00 none (switch gap) |
| fail_flag | output | 1 | Sticky external clock failure flag |
| fail_irq | output | 1 | Failure interrupt request |

## Verification
On every internal clock cycle the assertions check the following. The two gates are never seen open at once. A failure rises only in a monitored state and always coincides with the fallback state. The flag holds until it is cleared. A failure blocks any move toward the external clock. The stall counter stays inside its window. Only the bench scenarios can show the rest:
- that sys_clk really follows the chosen oscillator, which is measured by counting its edges;
- that a switch finishes in bounded time;
- that the fallback happens when the external oscillator halts mid-run or never starts;
- that a halted oscillator is ignored while the internal one is selected.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
    typedef enum logic [2:0] {
        ST_INT       = 3'd0,
        ST_DROP_INT  = 3'd1,
        ST_RAISE_EXT = 3'd2,
        ST_EXT       = 3'd3,
        ST_DROP_EXT  = 3'd4,
        ST_RAISE_INT = 3'd5
    } sel_state_t;

    localparam logic [1:0] SRC_NONE = 2'b00;
    localparam logic [1:0] SRC_INT  = 2'b01;
    localparam logic [1:0] SRC_EXT  = 2'b10;
endpackage

// File: rtl/cfm_gate_branch.sv
// One branch of the glitch-free clock switch. The enable is synchronised
// in the branch's own domain, and the gate changes only on a falling edge.
module cfm_gate_branch #(
    parameter int SYNC_STAGES = 2,
    parameter bit ON_AT_RESET = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_off,
    input  logic en_req,
    output logic gate
);
    logic                   arst_n;
    logic [SYNC_STAGES-1:0] sync_q;

    // The forced clear is only used once the branch clock has stopped.
    assign arst_n = rst_n & ~force_off;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= {SYNC_STAGES{ON_AT_RESET}};
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], en_req};
    end

    always_ff @(negedge clk or negedge arst_n) begin
        if (!arst_n) gate <= ON_AT_RESET;
        else         gate <= sync_q[SYNC_STAGES-1];
    end
endmodule

// File: rtl/cfm_activity_mon.sv
// Round-trip activity check: a token toggled in the internal domain must be
// echoed back through the external domain within STALL_CYCLES cycles.
module cfm_activity_mon #(
    parameter int SYNC_STAGES  = 2,
    parameter int STALL_CYCLES = 8
) (
    input  logic int_clk,
    input  logic ext_clk,
    input  logic rst_n,
    input  logic enable,
    output logic stalled
);
    localparam int CW = $clog2(STALL_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(STALL_CYCLES);

    logic                   token_q;
    logic [SYNC_STAGES-1:0] echo_q;
    logic [SYNC_STAGES-1:0] back_q;
    logic [CW-1:0]          idle_q;

    always_ff @(posedge ext_clk or negedge rst_n) begin
        if (!rst_n) echo_q <= '0;
        else        echo_q <= {echo_q[SYNC_STAGES-2:0], token_q};
    end

    always_ff @(posedge int_clk or negedge rst_n) begin
        if (!rst_n) back_q <= '0;
        else        back_q <= {back_q[SYNC_STAGES-2:0], echo_q[SYNC_STAGES-1]};
    end

    always_ff @(posedge int_clk or negedge rst_n) begin
        if (!rst_n) begin
            token_q <= 1'b0;
            idle_q  <= '0;
        end else if (!enable) begin
            idle_q  <= '0;
        end else if (back_q[SYNC_STAGES-1] == token_q) begin
            token_q <= ~token_q;
            idle_q  <= '0;
        end else if (idle_q != LIMIT) begin
            idle_q  <= idle_q + 1'b1;
        end
    end

    assign stalled = enable && (idle_q == LIMIT);

    AST_IDLE_BOUNDED: assert property (@(posedge int_clk) disable iff (!rst_n)
        idle_q <= LIMIT); // R5
    AST_IDLE_OFF_WHEN_DISABLED: assert property (@(posedge int_clk) disable iff (!rst_n)
        !enable |=> (idle_q == '0)); // R9
endmodule

// File: rtl/clk_fallback_sel.sv
module clk_fallback_sel #(
    parameter int SYNC_STAGES  = 2,
    parameter int STALL_CYCLES = 8
) (
    input  logic       int_clk,
    input  logic       ext_clk,
    input  logic       rst_n,
    input  logic       sel_ext,
    input  logic       irq_en,
    input  logic       fail_clr,
    output logic       sys_clk,
    output logic [1:0] active_src,
    output logic       fail_flag,
    output logic       fail_irq
);
    import cfm_pkg::*;

    sel_state_t             state_q, state_d;
    logic                   fail_q, fail_d;
    logic                   want_int_q, want_int_d;
    logic                   want_ext_q, want_ext_d;
    logic                   force_q, force_d;
    logic                   gate_int, gate_ext;
    logic [SYNC_STAGES-1:0] ack_q;
    logic                   ext_ack;
    logic                   mon_en;
    logic                   stalled;

    // Internal branch: open at reset, never force-cleared.
    cfm_gate_branch #(.SYNC_STAGES(SYNC_STAGES), .ON_AT_RESET(1'b1)) u_int_br (
        .clk(int_clk), .rst_n(rst_n), .force_off(1'b0),
        .en_req(want_int_q), .gate(gate_int)
    );

    // External branch: forced shut when its clock is known dead.
    cfm_gate_branch #(.SYNC_STAGES(SYNC_STAGES), .ON_AT_RESET(1'b0)) u_ext_br (
        .clk(ext_clk), .rst_n(rst_n), .force_off(force_q),
        .en_req(want_ext_q), .gate(gate_ext)
    );

    always_ff @(posedge int_clk or negedge rst_n) begin
        if (!rst_n) ack_q <= '0;
        else        ack_q <= {ack_q[SYNC_STAGES-2:0], gate_ext};
    end
    assign ext_ack = ack_q[SYNC_STAGES-1];

    assign mon_en = !fail_q &&
                    (state_q == ST_RAISE_EXT || state_q == ST_EXT || state_q == ST_DROP_EXT);

    cfm_activity_mon #(.SYNC_STAGES(SYNC_STAGES), .STALL_CYCLES(STALL_CYCLES)) u_mon (
        .int_clk(int_clk), .ext_clk(ext_clk), .rst_n(rst_n),
        .enable(mon_en), .stalled(stalled)
    );

    // State register process
    always_ff @(posedge int_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_INT;
            fail_q     <= 1'b0;
            want_int_q <= 1'b1;
            want_ext_q <= 1'b0;
            force_q    <= 1'b0;
        end else begin
            state_q    <= state_d;
            fail_q     <= fail_d;
            want_int_q <= want_int_d;
            want_ext_q <= want_ext_d;
            force_q    <= force_d;
        end
    end

    // Next-state and output process
    always_comb begin
        state_d = state_q;
        fail_d  = fail_q;
        if (stalled)       fail_d = 1'b1;
        else if (fail_clr) fail_d = 1'b0;
        unique case (state_q)
            ST_INT:       if (sel_ext && !fail_q) state_d = ST_DROP_INT;
            ST_DROP_INT:  if (!gate_int)          state_d = ST_RAISE_EXT;
            ST_RAISE_EXT: if (stalled || !sel_ext) state_d = ST_DROP_EXT;
                          else if (ext_ack)        state_d = ST_EXT;
            ST_EXT:       if (stalled || !sel_ext) state_d = ST_DROP_EXT;
            ST_DROP_EXT:  if (!ext_ack)           state_d = ST_RAISE_INT;
            ST_RAISE_INT: if (gate_int)           state_d = ST_INT;
            default:                              state_d = ST_INT;
        endcase
        want_int_d = (state_d == ST_INT) || (state_d == ST_RAISE_INT);
        want_ext_d = (state_d == ST_RAISE_EXT) || (state_d == ST_EXT);
        force_d    = (state_d == ST_DROP_EXT) && fail_d;
    end

    assign sys_clk    = (int_clk & gate_int) | (ext_clk & gate_ext);
    assign active_src = {ext_ack, gate_int};
    assign fail_flag  = fail_q;
    assign fail_irq   = fail_q & irq_en;

    AST_ONE_SOURCE: assert property (@(posedge int_clk) disable iff (!rst_n)
        !(gate_int && ext_ack)); // R3
    AST_FAIL_AT_FALLBACK: assert property (@(posedge int_clk) disable iff (!rst_n)
        $rose(fail_q) |-> (state_q == ST_DROP_EXT)); // R5
    AST_FAIL_ONLY_MONITORED: assert property (@(posedge int_clk) disable iff (!rst_n)
        $rose(fail_q) |-> ($past(state_q) == ST_RAISE_EXT || $past(state_q) == ST_EXT ||
                           $past(state_q) == ST_DROP_EXT)); // R9
    AST_FAIL_STICKY: assert property (@(posedge int_clk) disable iff (!rst_n)
        (fail_q && !fail_clr) |=> fail_q); // R7
    AST_REFUSE_WHILE_FAIL: assert property (@(posedge int_clk) disable iff (!rst_n)
        (state_q == ST_INT && fail_q) |=> (state_q == ST_INT)); // R8
endmodule

// File: tb/tb_clk_fallback_sel.sv
`timescale 1ns/1ps
module tb_clk_fallback_sel;
    logic       int_clk = 1'b0;
    logic       ext_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       sel_ext = 1'b0;
    logic       irq_en  = 1'b0;
    logic       fail_clr = 1'b0;
    logic       sys_clk;
    logic [1:0] active_src;
    logic       fail_flag;
    logic       fail_irq;
    bit         ext_run = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;
    int edge_cnt = 0;
    bit overlap_seen = 1'b0;
    bit gap_seen = 1'b0;

    typedef struct {
        string      tag;
        logic [1:0] act;
        logic       fail;
        logic       irq;
    } exp_t;
    exp_t sb_q[$];

    clk_fallback_sel dut (
        .int_clk(int_clk), .ext_clk(ext_clk), .rst_n(rst_n), .sel_ext(sel_ext),
        .irq_en(irq_en), .fail_clr(fail_clr), .sys_clk(sys_clk),
        .active_src(active_src), .fail_flag(fail_flag), .fail_irq(fail_irq)
    );

    always #5 int_clk = ~int_clk;
    initial forever begin
        #3.5;
        if (ext_run) ext_clk = ~ext_clk;
    end

    always @(posedge sys_clk) edge_cnt++;
    always @(negedge int_clk) if (rst_n) begin
        if (active_src == 2'b11) overlap_seen = 1'b1;
        if (active_src == 2'b00) gap_seen = 1'b1;
    end

    // Monitor: pops expected items and compares with the outputs.
    initial forever begin
        exp_t e;
        wait (sb_q.size() != 0);
        e = sb_q.pop_front();
        n_tests++;
        if (active_src !== e.act || fail_flag !== e.fail || fail_irq !== e.irq) begin
            n_fail++;
            $display("FAIL %s: act=%b fail=%b irq=%b expected act=%b fail=%b irq=%b",
                     e.tag, active_src, fail_flag, fail_irq, e.act, e.fail, e.irq);
        end
    end

    // Driver side: push an expectation, sampled at a falling edge.
    task automatic expect_out(input string tag, input logic [1:0] a, input logic f, input logic i);
        exp_t e;
        e.tag = tag; e.act = a; e.fail = f; e.irq = i;
        sb_q.push_back(e);
        #0;
        wait (sb_q.size() == 0);
    endtask

    task automatic check_range(input string tag, input int val, input int lo, input int hi);
        n_tests++;
        if (val < lo || val > hi) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected %0d..%0d", tag, val, lo, hi);
        end
    endtask

    task automatic wait_src(input logic [1:0] want, input int maxc);
        for (int k = 0; k < maxc; k++) begin
            @(negedge int_clk);
            if (active_src == want) return;
        end
    endtask

    task automatic wait_fail(input int maxc);
        for (int k = 0; k < maxc; k++) begin
            @(negedge int_clk);
            if (fail_flag) return;
        end
    endtask

    task automatic count_edges(output int n);
        int s;
        s = edge_cnt;
        #200;
        n = edge_cnt - s;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge int_clk);
    endtask

    initial begin : watchdog
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stimulus
        int n;
        idle(3);
        rst_n = 1'b1;
        idle(4);
        // R1: reset state
        expect_out("R1 reset", 2'b01, 1'b0, 1'b0);
        count_edges(n);
        check_range("R1 sys_clk internal rate", n, 19, 21);

        // R9: stopped external clock while internal selected
        ext_run = 1'b0;
        idle(40);
        expect_out("R9 no failure on internal", 2'b01, 1'b0, 1'b0);
        ext_run = 1'b1;
        idle(4);

        // R2, R3: switch to external
        irq_en = 1'b1;
        gap_seen = 1'b0;
        @(negedge int_clk) sel_ext = 1'b1;
        wait_src(2'b10, 30);
        expect_out("R2 switched to external", 2'b10, 1'b0, 1'b0);
        n_tests++;
        if (!gap_seen) begin
            n_fail++;
            $display("FAIL R3: actual gap_seen=0 expected 1");
        end
        count_edges(n);
        check_range("R2 sys_clk external rate", n, 27, 30);

        // R4: return to internal on request
        @(negedge int_clk) sel_ext = 1'b0;
        wait_src(2'b01, 30);
        expect_out("R4 back to internal", 2'b01, 1'b0, 1'b0);

        // R5, R6: external stops while selected
        @(negedge int_clk) sel_ext = 1'b1;
        wait_src(2'b10, 30);
        expect_out("R5 on external before stop", 2'b10, 1'b0, 1'b0);
        ext_run = 1'b0;
        wait_fail(16);
        n_tests++;
        if (!fail_flag) begin
            n_fail++;
            $display("FAIL R5: actual fail=0 expected 1 within 16 cycles");
        end
        wait_src(2'b01, 30);
        expect_out("R5 R6 fallback with irq", 2'b01, 1'b1, 1'b1);
        count_edges(n);
        check_range("R5 sys_clk internal after fallback", n, 19, 21);

        // R8: request refused while flag set
        ext_run = 1'b1;
        idle(40);
        expect_out("R8 request refused", 2'b01, 1'b1, 1'b1);
        // R6: interrupt masked
        @(negedge int_clk) irq_en = 1'b0;
        expect_out("R6 irq masked", 2'b01, 1'b1, 1'b0);
        // R7: sticky, then cleared
        idle(20);
        expect_out("R7 flag sticky", 2'b01, 1'b1, 1'b0);
        @(negedge int_clk) fail_clr = 1'b1;
        @(negedge int_clk) fail_clr = 1'b0;
        n_tests++;
        if (fail_flag !== 1'b0) begin
            n_fail++;
            $display("FAIL R7: actual fail=%b expected 0 after clear", fail_flag);
        end
        wait_src(2'b10, 30);
        expect_out("R8 request served after clear", 2'b10, 1'b0, 1'b0);

        // R10: external never starts
        @(negedge int_clk) sel_ext = 1'b0;
        wait_src(2'b01, 30);
        ext_run = 1'b0;
        idle(4);
        @(negedge int_clk) sel_ext = 1'b1;
        wait_fail(40);
        wait_src(2'b01, 30);
        expect_out("R10 dead external rejected", 2'b01, 1'b1, 1'b0);

        n_tests++;
        if (overlap_seen) begin
            n_fail++;
            $display("FAIL R3: actual overlap_seen=1 expected 0");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule